// File: doc/BRIEF.md
# Half-duplex SPI command engine

This block is an SPI master that runs one command at a time. Each command is framed by a chip select, and all of its data passes through one shared 70-byte buffer. A host on a simple byte-wide register port sets up a command. It loads an opcode byte, fills the buffer with the bytes that follow the opcode, picks one of four chip-select lines, and sets a transmit count and a receive count. It then writes the execute bit.

The engine asserts the selected chip select. It shifts out the opcode and then the transmit bytes from the buffer. After that it clocks in the receive bytes and stores them in the buffer, starting right after the transmitted bytes. It then releases chip select and clears busy. Transmission always completes before any reception begins, so the address bytes and the data bytes of a device access share one chip-select window.

The host can fill the buffer in two ways. It can write each byte at its own address, or it can use a streaming port that writes at an internal pointer and advances it. A control bit rewinds that pointer to zero. SCLK runs in mode 0 at a fixed division of the system clock.

Top module: `hdx_spi_engine`

## Requirements
- R1: After reset every chip-select line is high, SCLK and MOSI are low, and the status register (0x4C) reads 0: bit 0 is busy and bit 1 is error.
- R2: A command shifts out the opcode register (0x48) first, then buffer bytes 0 up to the transmit count (0x4A) minus one, in that order. Each byte goes MSB first in mode 0: MOSI changes only while SCLK is low, and the engine samples on the rising edge.
- R3: After the last transmit byte, the engine clocks in as many bytes as the receive count (0x4B) gives, with MOSI held low. Received byte k is stored at buffer index transmit count + k.
- R4: The select register (0x49, bits 1:0) picks which chip-select line goes low for a command. Only that line is low, and it stays low from before the first SCLK edge until after the last one.
- R5: Writing 1 to bit 0 of 0x4C starts a valid command. Busy reads 1 from the cycle after that write, and it returns to 0 on the same clock edge on which chip select is released.
- R6: If transmit count + receive count is greater than 70, execute sets the error bit and starts nothing. A sum of exactly 70 is accepted, and an accepted execute clears the error bit.
- R7: While busy, host writes to the buffer and to every register are ignored.
- R8: Each write to 0x47 stores its byte at the internal buffer pointer and then advances the pointer. Writing 1 to bit 2 of 0x4C returns the pointer to index 0. Buffer bytes are also readable and writable directly at addresses 0x00 to 0x45.
- R9: Each frame has exactly 8 × (1 + transmit count + receive count) rising SCLK edges. With a receive count of 0, chip select is released right after the last transmit byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 7 | Host register/buffer address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational from address) |
| busy | output | 1 | Command in progress |
| spi_sclk | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
Busy is due one clock after the edge that takes the execute write, so the bench reads status 1 ns after that edge and not on a later cycle. Each MOSI byte can be checked at its eighth rising SCLK edge, because MOSI only moves while SCLK is low. A bench-side slave model therefore compares each MOSI byte against a queue that the command task filled ahead of time. Chip select and busy change on the same edge, so when the polling loop first reads busy as 0 on a falling clock edge, all chip-select lines must already be high. Only then does the bench read back the buffer, the receive region and the contents that must have been preserved.

// File: rtl/hdx_spi_pkg.sv
package hdx_spi_pkg;
    localparam logic [6:0] ADR_STREAM = 7'h47;
    localparam logic [6:0] ADR_OPCODE = 7'h48;
    localparam logic [6:0] ADR_SELECT = 7'h49;
    localparam logic [6:0] ADR_TXCNT  = 7'h4A;
    localparam logic [6:0] ADR_RXCNT  = 7'h4B;
    localparam logic [6:0] ADR_CTRL   = 7'h4C;

    localparam int CTRL_EXEC  = 0;
    localparam int CTRL_PCLR  = 2;
    localparam int STAT_BUSY  = 0;
    localparam int STAT_ERR   = 1;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_LOAD  = 2'd1,
        SEQ_SHIFT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/hdx_spi_regs.sv
module hdx_spi_regs
    import hdx_spi_pkg::*;
#(
    parameter int BUF_BYTES = 70,
    parameter int CS_LINES  = 4,
    localparam int CW    = $clog2(BUF_BYTES + 1),
    localparam int SEL_W = $clog2(CS_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [6:0]       host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic             busy_i,
    input  logic [CW-1:0]    eng_addr,
    output logic [7:0]       eng_rdata,
    input  logic             eng_we,
    input  logic [7:0]       eng_wdata,
    output logic [7:0]       opcode_o,
    output logic [SEL_W-1:0] sel_o,
    output logic [CW-1:0]    txc_o,
    output logic [CW-1:0]    rxc_o,
    output logic             go_o,
    output logic             err_o
);
    localparam logic [6:0]  BUF_END   = 7'(BUF_BYTES);
    localparam logic [CW-1:0] PTR_END = CW'(BUF_BYTES);
    localparam logic [CW:0] SUM_LIMIT = (CW + 1)'(BUF_BYTES);

    typedef struct packed {
        logic [BUF_BYTES-1:0][7:0] mem;
        logic [7:0]       opcode;
        logic [SEL_W-1:0] sel;
        logic [CW-1:0]    txc;
        logic [CW-1:0]    rxc;
        logic [CW-1:0]    ptr;
        logic             err;
        logic             go;
    } regs_t;

    regs_t d, q;
    logic [CW:0] count_sum;

    assign count_sum = {1'b0, q.txc} + {1'b0, q.rxc};

    always_comb begin
        d    = q;
        d.go = 1'b0;
        if (eng_we && (eng_addr < PTR_END)) begin
            d.mem[eng_addr] = eng_wdata;
        end
        if (host_we && !busy_i) begin
            if (host_addr < BUF_END) begin
                d.mem[host_addr] = host_wdata;
            end else begin
                case (host_addr)
                    ADR_STREAM: begin
                        if (q.ptr < PTR_END) begin
                            d.mem[q.ptr] = host_wdata;
                            d.ptr        = q.ptr + CW'(1);
                        end
                    end
                    ADR_OPCODE: d.opcode = host_wdata;
                    ADR_SELECT: d.sel    = host_wdata[SEL_W-1:0];
                    ADR_TXCNT:  d.txc    = host_wdata[CW-1:0];
                    ADR_RXCNT:  d.rxc    = host_wdata[CW-1:0];
                    ADR_CTRL: begin
                        if (host_wdata[CTRL_PCLR]) begin
                            d.ptr = '0;
                        end
                        if (host_wdata[CTRL_EXEC]) begin
                            if (count_sum > SUM_LIMIT) begin
                                d.err = 1'b1;
                            end else begin
                                d.err = 1'b0;
                                d.go  = 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        host_rdata = 8'h00;
        if (host_addr < BUF_END) begin
            host_rdata = q.mem[host_addr];
        end else begin
            case (host_addr)
                ADR_OPCODE: host_rdata = q.opcode;
                ADR_SELECT: host_rdata = 8'(q.sel);
                ADR_TXCNT:  host_rdata = 8'(q.txc);
                ADR_RXCNT:  host_rdata = 8'(q.rxc);
                ADR_CTRL: begin
                    host_rdata[STAT_BUSY] = busy_i;
                    host_rdata[STAT_ERR]  = q.err;
                end
                default: host_rdata = 8'h00;
            endcase
        end
    end

    assign eng_rdata = q.mem[eng_addr];
    assign opcode_o  = q.opcode;
    assign sel_o     = q.sel;
    assign txc_o     = q.txc;
    assign rxc_o     = q.rxc;
    assign go_o      = q.go;
    assign err_o     = q.err;

    // R6
    go_without_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.go |-> !q.err);

    // R7
    frozen_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(q.opcode) && $stable(q.sel) && $stable(q.txc)
                    && $stable(q.rxc) && $stable(q.ptr)));
endmodule

// File: rtl/hdx_spi_shift.sv
module hdx_spi_shift #(
    parameter int HALF_DIV = 2,
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam logic [DW-1:0] CNT_LAST = DW'(HALF_DIV - 1);

    typedef struct packed {
        logic          active;
        logic          sclk;
        logic [7:0]    sr;
        logic [7:0]    rx;
        logic [2:0]    bitn;
        logic [DW-1:0] cnt;
    } shift_t;

    shift_t d, q;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (start && !q.active) begin
            d.active = 1'b1;
            d.sclk   = 1'b0;
            d.sr     = tx_byte;
            d.bitn   = '0;
            d.cnt    = '0;
        end else if (q.active) begin
            if (q.cnt == CNT_LAST) begin
                d.cnt = '0;
                if (!q.sclk) begin
                    d.sclk = 1'b1;
                    d.rx   = {q.rx[6:0], miso};
                end else begin
                    d.sclk = 1'b0;
                    if (q.bitn == 3'd7) begin
                        d.active = 1'b0;
                        done     = 1'b1;
                    end else begin
                        d.bitn = q.bitn + 3'd1;
                        d.sr   = {q.sr[6:0], 1'b0};
                    end
                end
            end else begin
                d.cnt = q.cnt + DW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sclk    = q.sclk;
    assign mosi    = q.active & q.sr[7];
    assign rx_byte = q.rx;

    // R2
    mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sclk && $past(q.sclk)) |-> $stable(mosi));
endmodule

// File: rtl/hdx_spi_seq.sv
module hdx_spi_seq
    import hdx_spi_pkg::*;
#(
    parameter int BUF_BYTES = 70,
    parameter int CS_LINES  = 4,
    localparam int CW    = $clog2(BUF_BYTES + 1),
    localparam int SEL_W = $clog2(CS_LINES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [7:0]          opcode,
    input  logic [SEL_W-1:0]    sel,
    input  logic [CW-1:0]       txc,
    input  logic [CW-1:0]       rxc,
    input  logic [7:0]          buf_rdata,
    input  logic                sh_done,
    input  logic [7:0]          sh_rx,
    output logic [CW-1:0]       buf_addr,
    output logic                buf_we,
    output logic [7:0]          buf_wdata,
    output logic                sh_start,
    output logic [7:0]          sh_tx,
    output logic [CS_LINES-1:0] cs_n,
    output logic                busy,
    output logic                rx_phase
);
    typedef struct packed {
        seq_state_e          state;
        logic [CW-1:0]       idx;
        logic [CW-1:0]       last;
        logic [CW-1:0]       txc;
        logic [CS_LINES-1:0] cs_n;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d        = q;
        sh_start = 1'b0;
        buf_we   = 1'b0;
        case (q.state)
            SEQ_IDLE: begin
                if (go) begin
                    d.state = SEQ_LOAD;
                    d.idx   = '0;
                    d.last  = txc + rxc;
                    d.txc   = txc;
                    for (int i = 0; i < CS_LINES; i++) begin
                        d.cs_n[i] = (sel != SEL_W'(i));
                    end
                end
            end
            SEQ_LOAD: begin
                sh_start = 1'b1;
                d.state  = SEQ_SHIFT;
            end
            SEQ_SHIFT: begin
                if (sh_done) begin
                    buf_we = (q.idx > q.txc);
                    if (q.idx == q.last) begin
                        d.state = SEQ_IDLE;
                        d.cs_n  = '1;
                    end else begin
                        d.idx   = q.idx + CW'(1);
                        d.state = SEQ_LOAD;
                    end
                end
            end
            default: d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= SEQ_IDLE;
            q.cs_n  <= '1;
        end else begin
            q <= d;
        end
    end

    assign buf_addr  = (q.idx == '0) ? '0 : (q.idx - CW'(1));
    assign buf_wdata = sh_rx;
    assign sh_tx     = (q.idx == '0) ? opcode :
                       (q.idx <= q.txc) ? buf_rdata : 8'h00;
    assign cs_n      = q.cs_n;
    assign busy      = (q.state != SEQ_IDLE);
    assign rx_phase  = (q.state != SEQ_IDLE) && (q.idx > q.txc);

    // R4
    single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R3
    rx_store_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (buf_addr >= q.txc));
endmodule

// File: rtl/hdx_spi_engine.sv
module hdx_spi_engine #(
    parameter int BUF_BYTES = 70,
    parameter int HALF_DIV  = 2,
    parameter int CS_LINES  = 4,
    localparam int CW    = $clog2(BUF_BYTES + 1),
    localparam int SEL_W = $clog2(CS_LINES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [6:0]          host_addr,
    input  logic [7:0]          host_wdata,
    output logic [7:0]          host_rdata,
    output logic                busy,
    output logic                spi_sclk,
    output logic                spi_mosi,
    input  logic                spi_miso,
    output logic [CS_LINES-1:0] spi_cs_n
);
    logic [CW-1:0]    eng_addr;
    logic [7:0]       eng_rdata;
    logic             eng_we;
    logic [7:0]       eng_wdata;
    logic [7:0]       opcode;
    logic [SEL_W-1:0] sel;
    logic [CW-1:0]    txc;
    logic [CW-1:0]    rxc;
    logic             go;
    logic             err;
    logic             seq_busy;
    logic             rx_phase;
    logic             sh_start;
    logic [7:0]       sh_tx;
    logic             sh_done;
    logic [7:0]       sh_rx;

    assign busy = go | seq_busy;

    hdx_spi_regs #(.BUF_BYTES(BUF_BYTES), .CS_LINES(CS_LINES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy_i     (busy),
        .eng_addr   (eng_addr),
        .eng_rdata  (eng_rdata),
        .eng_we     (eng_we),
        .eng_wdata  (eng_wdata),
        .opcode_o   (opcode),
        .sel_o      (sel),
        .txc_o      (txc),
        .rxc_o      (rxc),
        .go_o       (go),
        .err_o      (err)
    );

    hdx_spi_seq #(.BUF_BYTES(BUF_BYTES), .CS_LINES(CS_LINES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .opcode    (opcode),
        .sel       (sel),
        .txc       (txc),
        .rxc       (rxc),
        .buf_rdata (eng_rdata),
        .sh_done   (sh_done),
        .sh_rx     (sh_rx),
        .buf_addr  (eng_addr),
        .buf_we    (eng_we),
        .buf_wdata (eng_wdata),
        .sh_start  (sh_start),
        .sh_tx     (sh_tx),
        .cs_n      (spi_cs_n),
        .busy      (seq_busy),
        .rx_phase  (rx_phase)
    );

    hdx_spi_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    // R4
    sclk_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !(&spi_cs_n));

    // R3
    rx_mosi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_phase |-> !spi_mosi);

    // R6
    err_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !seq_busy) |=> !seq_busy);
endmodule

// File: tb/hdx_spi_engine_tb.sv
`timescale 1ns/100ps
module hdx_spi_engine_tb;
    localparam logic [6:0] A_STREAM = 7'h47;
    localparam logic [6:0] A_OPC    = 7'h48;
    localparam logic [6:0] A_SEL    = 7'h49;
    localparam logic [6:0] A_TXC    = 7'h4A;
    localparam logic [6:0] A_RXC    = 7'h4B;
    localparam logic [6:0] A_CTRL   = 7'h4C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [6:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       busy;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_miso = 1'b0;
    logic [3:0] spi_cs_n;

    always #2.5 clk = ~clk;

    hdx_spi_engine u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .spi_sclk   (spi_sclk),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso),
        .spi_cs_n   (spi_cs_n)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'h5A ^ 8'(k * 29);
    endfunction

    // scoreboard queues
    logic [7:0] exp_mosi[$];
    string      exp_tag[$];
    int         exp_cs[$];
    int         exp_bits[$];

    // slave model and monitor
    wire        cs_idle = &spi_cs_n;
    int         frames = 0;
    bit         in_frame = 1'b0;
    int         fr_k, fr_bit, rises;
    logic [7:0] cur, mosi_sr;

    always @(negedge cs_idle) begin : frame_open
        int got;
        int e;
        got = -1;
        for (int i = 0; i < 4; i++) if (!spi_cs_n[i]) got = i;
        frames++;
        in_frame = 1'b1;
        fr_k = 0; fr_bit = 7; rises = 0;
        cur = pat(0);
        spi_miso = cur[7];
        if (exp_cs.size() == 0) begin
            chk(1'b0, "R4/R6 frame without accepted command", got, -1);
        end else begin
            e = exp_cs.pop_front();
            chk(got == e && $countones(~spi_cs_n) == 1, "R4 chip select line", got, e);
        end
    end

    always @(negedge spi_sclk) begin
        if (!cs_idle) begin
            if (fr_bit == 0) begin
                fr_bit = 7;
                fr_k++;
                cur = pat(fr_k);
            end else begin
                fr_bit--;
            end
            spi_miso = cur[fr_bit];
        end
    end

    always @(posedge spi_sclk) begin : mosi_mon
        logic [7:0] e;
        string t;
        rises++;
        mosi_sr = {mosi_sr[6:0], spi_mosi};
        if (rises % 8 == 0) begin
            if (exp_mosi.size() == 0) begin
                chk(1'b0, "R2 unexpected MOSI byte", mosi_sr, 0);
            end else begin
                e = exp_mosi.pop_front();
                t = exp_tag.pop_front();
                chk(mosi_sr == e, t, mosi_sr, e);
            end
        end
    end

    always @(posedge cs_idle) begin : frame_close
        int e;
        if (in_frame) begin
            in_frame = 1'b0;
            if (exp_bits.size() != 0) begin
                e = exp_bits.pop_front();
                chk(rises == e, "R9 SCLK rising edges per frame", rises, e);
            end
        end
    end

    // driver tasks
    logic [7:0] txd[0:69];

    task automatic wr(input logic [6:0] a, input logic [7:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = v;
        @(posedge clk);
        #1;
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] v);
        @(negedge clk);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(A_CTRL, s);
            if (!s[0]) break;
        end
        chk(spi_cs_n == 4'hF, "R5 chip select released when busy clears", spi_cs_n, 4'hF);
    endtask

    task automatic run_cmd(input logic [7:0] op, input int sel, input int txc,
                           input int rxc, input bit load_buf, input bit poke);
        logic [7:0] s;
        if (load_buf) for (int i = 0; i < txc; i++) wr(7'(i), txd[i]);
        wr(A_OPC, op);
        wr(A_SEL, 8'(sel));
        wr(A_TXC, 8'(txc));
        wr(A_RXC, 8'(rxc));
        exp_cs.push_back(sel);
        exp_mosi.push_back(op); exp_tag.push_back("R2 opcode byte");
        for (int i = 0; i < txc; i++) begin
            exp_mosi.push_back(txd[i]); exp_tag.push_back("R2 transmit byte");
        end
        for (int i = 0; i < rxc; i++) begin
            exp_mosi.push_back(8'h00); exp_tag.push_back("R3 MOSI low while receiving");
        end
        exp_bits.push_back(8 * (1 + txc + rxc));
        wr(A_CTRL, 8'h01);
        host_addr = A_CTRL;
        #1;
        chk(host_rdata[0] == 1'b1, "R5 busy in cycle after execute", host_rdata[0], 1);
        if (poke) begin
            wr(7'h00, ~txd[0]);
            wr(A_OPC, ~op);
            wr(A_TXC, 8'h05);
        end
        wait_idle();
        rd(A_CTRL, s);
        chk(s[1] == 1'b0, "R6 error clear after accepted command", s[1], 0);
        for (int j = 0; j < rxc; j++) begin
            rd(7'(txc + j), s);
            chk(s == pat(1 + txc + j), "R3 received byte at transmit-count offset", s, pat(1 + txc + j));
        end
        for (int j = 0; j < txc; j++) begin
            rd(7'(j), s);
            chk(s == txd[j], "R7 transmit bytes kept in buffer", s, txd[j]);
        end
        if (poke) begin
            rd(A_OPC, s);
            chk(s == op, "R7 opcode write ignored while busy", s, op);
            rd(A_TXC, s);
            chk(s == 8'(txc), "R7 count write ignored while busy", s, txc);
        end
    endtask

    initial begin : main
        logic [7:0] s;
        int f0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(spi_cs_n == 4'hF, "R1 chip selects high", spi_cs_n, 4'hF);
        chk(spi_sclk == 1'b0, "R1 SCLK low", spi_sclk, 0);
        chk(spi_mosi == 1'b0, "R1 MOSI low", spi_mosi, 0);
        chk(busy == 1'b0, "R1 busy low", busy, 0);
        rd(A_CTRL, s);
        chk(s == 8'h00, "R1 status zero", s, 0);

        // read-style command: 3 tx, 4 rx on line 0
        for (int i = 0; i < 70; i++) txd[i] = 8'(8'hC3 + i * 7);
        run_cmd(8'h9F, 0, 3, 4, 1'b1, 1'b0);

        // write-only command on line 2, writes attempted while busy (R7, R9)
        for (int i = 0; i < 70; i++) txd[i] = 8'(8'h11 * (i + 1));
        run_cmd(8'h02, 2, 5, 0, 1'b1, 1'b1);

        // opcode then receive only, line 3
        run_cmd(8'h03, 3, 0, 2, 1'b1, 1'b0);

        // R6 overflow: 40 + 31 > 70
        f0 = frames;
        wr(A_TXC, 8'd40);
        wr(A_RXC, 8'd31);
        wr(A_CTRL, 8'h01);
        host_addr = A_CTRL;
        #1;
        chk(host_rdata[1] == 1'b1, "R6 error set on overflow", host_rdata[1], 1);
        chk(host_rdata[0] == 1'b0, "R6 no busy on overflow", host_rdata[0], 0);
        repeat (60) @(posedge clk);
        chk(frames == f0, "R6 no frame on overflow", frames, f0);

        // R6 exact 70 accepted, line 1
        for (int i = 0; i < 70; i++) txd[i] = 8'(8'h80 ^ (i * 3));
        run_cmd(8'hA5, 1, 30, 40, 1'b1, 1'b0);

        // R8 streaming fill
        wr(A_CTRL, 8'h04);
        wr(A_STREAM, 8'hD1);
        wr(A_STREAM, 8'hD2);
        wr(A_STREAM, 8'hD3);
        rd(7'h00, s); chk(s == 8'hD1, "R8 stream byte 0", s, 8'hD1);
        rd(7'h01, s); chk(s == 8'hD2, "R8 stream byte 1", s, 8'hD2);
        rd(7'h02, s); chk(s == 8'hD3, "R8 stream byte 2", s, 8'hD3);
        wr(A_CTRL, 8'h04);
        wr(A_STREAM, 8'hE7);
        rd(7'h00, s); chk(s == 8'hE7, "R8 pointer rewound to zero", s, 8'hE7);
        rd(7'h01, s); chk(s == 8'hD2, "R8 neighbour untouched", s, 8'hD2);
        txd[0] = 8'hE7; txd[1] = 8'hD2; txd[2] = 8'hD3;
        run_cmd(8'h5C, 1, 3, 1, 1'b0, 1'b0);

        chk(exp_mosi.size() == 0, "R2 all expected MOSI bytes seen", exp_mosi.size(), 0);
        chk(exp_cs.size() == 0, "R4 all expected frames seen", exp_cs.size(), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule